// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs single register transactions on a two-wire PHY management bus. A host pulses a start strobe with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces the management clock from the system clock and sequences the whole frame on the data line. The data line is bidirectional, so the block offers a separate output value, an output enable and an input.

Each frame opens with a long run of forty one-bits and then a start pattern and an opcode. The two addresses follow. For a write, the master drives a two-bit turnaround and the data word. For a read, it releases the line for a one-pulse turnaround and then shifts in the data word from the PHY. Both kinds of frame end with the line released and one spare clock pulse. Completion is signalled by a one-cycle done pulse. Read data is presented on a holding register.

The low and high phases of the management clock are both set by a parameter that counts system clocks.

Top module: `mdio_master`

## Requirements
- R1: Every frame starts with 40 management clock pulses, each with `mdio_out` = 1 and `mdio_oe` = 1 at its rising edge.
- R2: The next two pulses carry 0 then 1 (start), followed by the opcode: 1,0 for a read (`xfer_read` = 1) and 0,1 for a write. All four bits are driven.
- R3: The next ten driven pulses carry the PHY address bits 4..0 and then the register address bits 4..0, most significant bit first.
- R4: `mdio_out` and `mdio_oe` change only while `mdc` is low. Every high phase and every low phase of `mdc` inside a frame lasts `HALF_CLKS` system clocks.
- R5: On a write, the two pulses after the register address carry the driven bits 1 then 0. These are followed by the 16 bits of `wr_data`, bit 15 first, all driven.
- R6: On a read, `mdio_oe` is 0 from the pulse after the register address onward. That pulse is the turnaround. The next 16 pulses each sample `mdio_in` at their falling edge and shift it into the low end of the word, so the first sampled bit ends up as bit 15.
- R7: The final pulse of every frame has `mdio_oe` = 0. A read frame has 72 pulses in total and a write frame has 73.
- R8: `busy` rises in the cycle after an accepted start. `done` is high for exactly one system clock, in the first cycle where `busy` is low again.
- R9: A start strobe that arrives while `busy` is high is ignored, and the frame in progress keeps its addresses, opcode and data.
- R10: `rd_data` changes only in the cycle that `done` rises for a read. A write leaves it unchanged.
- R11: Right after reset, `mdc`, `mdio_oe`, `busy`, `done` and `rd_data` are all 0.
- R12: A start strobe given in the cycle where `done` is high is accepted, and a new complete frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | One-cycle request for a transaction |
| xfer_read | input | 1 | 1 selects a read, 0 selects a write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address inside the PHY |
| wr_data | input | 16 | Data for a write |
| rd_data | output | 16 | Last word returned by a read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Enable for the data line driver |
| mdio_in | input | 1 | Value sampled from the data line |

## Verification
Two things can happen in the same system clock: a transaction finishes (done pulses, busy drops and, for a read, the data register loads) and a new start strobe is accepted. The bench provokes this by raising the strobe in the very cycle where it sees done high. It then checks three things. The earlier read word must appear on rd_data, a fresh frame of the correct length must follow with the new addresses, and the phase timing must not be cut short. A second overlap is a strobe that lands mid-frame. That frame must come out bit for bit as originally requested.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
// Package: mdio_pkg
// Shared constants and the request type for the management master.
// Assumes the fixed management frame layout (5-bit addresses, 16-bit data).
package mdio_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int HEAD_FIX = 2 + 2 + 2 * ADDR_W;   // start + opcode + addresses

    localparam logic [1:0] START_PAT = 2'b01;
    localparam logic [1:0] OP_RD     = 2'b10;
    localparam logic [1:0] OP_WR     = 2'b01;
    localparam logic [1:0] TA_WR     = 2'b10;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;
endpackage

// File: rtl/mdc_phase_gen.sv
`timescale 1ns/1ps
// Module: mdc_phase_gen
// Produces the management clock phase while run is high. Each low and high
// phase lasts HALF_CLKS system clocks. slot_end pulses in the last cycle of
// a high phase, which is when the clock is about to fall.
// Assumes run goes high in the cycle after a start is accepted. While run is
// low the counter is held at the start of a low phase.
module mdc_phase_gen #(
    parameter int HALF_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc_high,
    output logic slot_end
);
    logic ph;
    logic last;

    generate
        if (HALF_CLKS > 1) begin : g_cnt
            localparam int CW = $clog2(HALF_CLKS);
            logic [CW-1:0] cnt;
            assign last = (cnt == CW'(HALF_CLKS - 1));
            // count system clocks within the current phase
            always_ff @(posedge clk) begin
                if (!rst_n || !run)  cnt <= '0;
                else if (last)       cnt <= '0;
                else                 cnt <= cnt + 1'b1;
            end
        end else begin : g_nocnt
            assign last = 1'b1;
        end
    endgenerate

    // toggle the phase at the end of each half-period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) ph <= 1'b0;
        else if (last)      ph <= ~ph;
    end

    assign mdc_high = ph;
    assign slot_end = run & last & ph;

    // a high phase is never seen with run low (clock parked low when idle)
    p_park_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !ph || run);
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
// Module: mdio_frame_seq
// Loads the full outgoing frame on an accepted start and shifts it one bit
// per management clock slot. It also decides when the line is driven,
// flags read sample slots and ends the transaction.
// Assumes slot_end pulses once per slot, at the mdc falling edge.
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 40
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  mdio_req_t req,
    input  logic      slot_end,
    output logic      busy,
    output logic      done,
    output logic      is_read,
    output logic      finish,
    output logic      capture,
    output logic      mdio_out,
    output logic      mdio_oe
);
    localparam int HDR     = PRE_BITS + HEAD_FIX;
    localparam int FRAME_W = HDR + 2 + DATA_W;
    localparam int LAST_RD = HDR + 1 + DATA_W;
    localparam int LAST_WR = HDR + 2 + DATA_W;
    localparam int SW      = $clog2(LAST_WR + 1);

    logic [FRAME_W-1:0] tx;
    logic [SW-1:0]      slot;
    logic               rd_q;
    logic               at_last;

    assign at_last = rd_q ? (slot == SW'(LAST_RD)) : (slot == SW'(LAST_WR));
    assign finish  = busy & slot_end & at_last;

    // accept requests, shift the frame and close the transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            rd_q <= 1'b0;
            slot <= '0;
            tx   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    slot <= '0;
                    rd_q <= req.rd;
                    tx   <= {{PRE_BITS{1'b1}}, START_PAT, (req.rd ? OP_RD : OP_WR),
                             req.phy, req.regad, TA_WR, req.wdata};
                end
            end else if (slot_end) begin
                tx <= {tx[FRAME_W-2:0], 1'b0};
                if (at_last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end

    assign is_read  = rd_q;
    assign mdio_oe  = busy & ((slot < SW'(HDR)) | (!rd_q & (slot < SW'(LAST_WR))));
    assign mdio_out = mdio_oe & tx[FRAME_W-1];
    assign capture  = busy & rd_q & slot_end &
                      (slot >= SW'(HDR + 1)) & (slot <= SW'(HDR + DATA_W));

    // done is a single cycle and comes with busy already low
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // the closing slot never drives the line
    p_release_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> !mdio_oe);
    // the opcode of a running frame cannot be replaced
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || rd_q == $past(rd_q)));
endmodule

// File: rtl/mdio_rx_capture.sv
`timescale 1ns/1ps
// Module: mdio_rx_capture
// Shifts sampled read bits into a word (low end first in, so the first bit
// ends up on top) and copies the word to the output when a read completes.
// Assumes capture pulses once per read data slot and finish once per frame.
module mdio_rx_capture
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              finish,
    input  logic              is_read,
    input  logic              mdio_in,
    input  logic              done,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sh;

    // collect read bits at each sample slot
    always_ff @(posedge clk) begin
        if (!rst_n)       sh <= '0;
        else if (capture) sh <= {sh[DATA_W-2:0], mdio_in};
    end

    // publish the word only when a read frame closes
    always_ff @(posedge clk) begin
        if (!rst_n)                   rd_data <= '0;
        else if (finish && is_read)   rd_data <= sh;
    end

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != $past(rd_data)) |-> (done && is_read));
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
// Module: mdio_master
// Top of the management master. It ties the phase generator, the frame
// sequencer and the read capture together. Assumes HALF_CLKS >= 1 and that
// the line has an external pull-up while nobody drives it.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CLKS = 2,
    parameter int PRE_BITS  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_read,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    mdio_req_t req;
    logic      slot_end;
    logic      is_read;
    logic      finish;
    logic      capture;

    assign req = '{rd: xfer_read, phy: phy_addr, regad: reg_addr, wdata: wr_data};

    mdc_phase_gen #(.HALF_CLKS(HALF_CLKS)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc_high (mdc),
        .slot_end (slot_end)
    );

    mdio_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (xfer_start),
        .req      (req),
        .slot_end (slot_end),
        .busy     (busy),
        .done     (done),
        .is_read  (is_read),
        .finish   (finish),
        .capture  (capture),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    mdio_rx_capture u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .finish   (finish),
        .is_read  (is_read),
        .mdio_in  (mdio_in),
        .done     (done),
        .rd_data  (rd_data)
    );

    // line value and enable hold still while the clock is high
    p_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));
    // an idle block neither drives the line nor clocks
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));
    // a read never drives the line once a sample slot is reached
    p_read_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !mdio_oe);
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int PRE        = 40;
    localparam int HDR        = PRE + 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic        xfer_read = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        busy, done, mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int failures = 0;

    mdio_master #(.HALF_CLKS(HALF), .PRE_BITS(PRE)) dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_read(xfer_read),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .done(done), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // current transaction as seen by the PHY model
    bit          cur_rd;
    bit [4:0]    cur_pa, cur_ra;
    bit [15:0]   cur_wd, cur_val;
    int          pc = 0;
    bit          oe_rec [0:127];
    bit          out_rec[0:127];
    int          phase_err = 0;
    int          done_long = 0;
    time         t_rise = 0, t_fall = 0;
    bit [15:0]   model_rd = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected driven bit for slot s of a frame
    function automatic bit exp_bit(int s, bit rd, bit [4:0] pa, bit [4:0] ra, bit [15:0] wd);
        if (s < PRE)            return 1'b1;
        if (s == PRE)           return 1'b0;
        if (s == PRE + 1)       return 1'b1;
        if (s == PRE + 2)       return rd;
        if (s == PRE + 3)       return ~rd;
        if (s < PRE + 9)        return pa[4 - (s - PRE - 4)];
        if (s < HDR)            return ra[4 - (s - PRE - 9)];
        if (s == HDR)           return 1'b1;
        if (s == HDR + 1)       return 1'b0;
        return wd[15 - (s - HDR - 2)];
    endfunction

    // PHY model: record rising-edge values, drive read bits, time the phases
    always @(posedge mdc) begin
        if (pc < 128) begin
            oe_rec[pc]  = mdio_oe;
            out_rec[pc] = mdio_out;
        end
        if (pc > 0 && ($time - t_fall) != HALF * CLK_PERIOD) phase_err++;
        t_rise = $time;
        if (cur_rd && pc >= HDR + 1 && pc <= HDR + 16) mdio_in = cur_val[15 - (pc - HDR - 1)];
        else if (cur_rd && pc == HDR)                  mdio_in = 1'b0;
        else                                           mdio_in = 1'b1;
        pc++;
    end

    always @(negedge mdc) begin
        if (($time - t_rise) != HALF * CLK_PERIOD) phase_err++;
        t_fall = $time;
    end

    bit done_prev = 1'b0;
    always @(negedge clk) begin
        if (done && done_prev) done_long++;
        done_prev = done;
    end

    task automatic start_txn(input bit rd, input bit [4:0] pa, input bit [4:0] ra,
                             input bit [15:0] wd, input bit [15:0] val);
        cur_rd = rd; cur_pa = pa; cur_ra = ra; cur_wd = wd; cur_val = val;
        pc = 0;
        phase_err = 0;
        xfer_read = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after accepted start", 32'(busy), 32'd1);
    endtask

    task automatic finish_txn(input bit inject);
        int  n = 0;
        bit  rd_before_ok;
        bit  ok;
        logic [15:0] rd_before;
        rd_before = rd_data;
        rd_before_ok = 1'b1;
        while (!done && n < 2000) begin
            if (inject && n == 30) begin
                xfer_start = 1'b1; xfer_read = ~cur_rd;
                phy_addr = ~cur_pa; reg_addr = ~cur_ra; wr_data = ~cur_wd;
            end else begin
                xfer_start = 1'b0;
            end
            if (rd_data != rd_before) rd_before_ok = 1'b0;
            @(negedge clk);
            n++;
        end
        xfer_start = 1'b0;
        if (n >= 2000) begin
            chk(1'b0, "R8", "watchdog waiting for done", 32'(n), 32'd0);
            return;
        end
        chk(rd_before_ok, "R10", "rd_data moved mid-frame", 32'(rd_data), 32'(rd_before));
        chk(busy == 1'b0, "R8", "busy low with done", 32'(busy), 32'd0);
        // R1 preamble
        ok = 1'b1;
        for (int s = 0; s < PRE; s++) if (!oe_rec[s] || !out_rec[s]) ok = 1'b0;
        chk(ok, "R1", "preamble ones driven", 32'(pc), 32'(PRE));
        // R2 start and opcode
        ok = 1'b1;
        for (int s = PRE; s < PRE + 4; s++)
            if (!oe_rec[s] || out_rec[s] != exp_bit(s, cur_rd, cur_pa, cur_ra, cur_wd)) ok = 1'b0;
        chk(ok, inject ? "R9" : "R2", "start and opcode", 32'({out_rec[PRE], out_rec[PRE+1],
            out_rec[PRE+2], out_rec[PRE+3]}), 32'({2'b01, cur_rd, ~cur_rd}));
        // R3 addresses
        ok = 1'b1;
        for (int s = PRE + 4; s < HDR; s++)
            if (!oe_rec[s] || out_rec[s] != exp_bit(s, cur_rd, cur_pa, cur_ra, cur_wd)) ok = 1'b0;
        chk(ok, inject ? "R9" : "R3", "phy and register address", 32'({cur_pa, cur_ra}), 32'({cur_pa, cur_ra}));
        chk(phase_err == 0, "R4", "mdc phase lengths", 32'(phase_err), 32'd0);
        if (cur_rd) begin
            ok = 1'b1;
            for (int s = HDR; s < HDR + 18; s++) if (oe_rec[s]) ok = 1'b0;
            chk(ok, "R6", "line released after address on read", 32'(oe_rec[HDR]), 32'd0);
            chk(rd_data == cur_val, "R6", "read word", 32'(rd_data), 32'(cur_val));
            chk(pc == HDR + 18, "R7", "read pulse count", 32'(pc), 32'(HDR + 18));
            model_rd = cur_val;
        end else begin
            ok = 1'b1;
            for (int s = HDR; s < HDR + 18; s++)
                if (!oe_rec[s] || out_rec[s] != exp_bit(s, 1'b0, cur_pa, cur_ra, cur_wd)) ok = 1'b0;
            chk(ok, inject ? "R9" : "R5", "turnaround and write data", 32'(cur_wd), 32'(cur_wd));
            chk(oe_rec[HDR + 18] == 1'b0, "R7", "trailing pulse released", 32'(oe_rec[HDR + 18]), 32'd0);
            chk(pc == HDR + 19, "R7", "write pulse count", 32'(pc), 32'(HDR + 19));
            chk(rd_data == model_rd, "R10", "rd_data after write", 32'(rd_data), 32'(model_rd));
        end
        if (cur_rd) chk(oe_rec[HDR + 17] == 1'b0, "R7", "read trailing pulse released",
                        32'(oe_rec[HDR + 17]), 32'd0);
    endtask

    task automatic run_txn(input bit rd, input bit [4:0] pa, input bit [4:0] ra,
                           input bit [15:0] wd, input bit [15:0] val, input bit inject);
        start_txn(rd, pa, ra, wd, val);
        finish_txn(inject);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done lasts one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1D0C);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk({mdc, mdio_oe, busy, done} == 4'b0, "R11", "control outputs after reset",
            32'({mdc, mdio_oe, busy, done}), 32'd0);
        chk(rd_data == 16'h0, "R11", "rd_data after reset", 32'(rd_data), 32'd0);

        // directed corners
        run_txn(1'b0, 5'h1F, 5'h00, 16'hFFFF, 16'h0, 1'b0);
        run_txn(1'b0, 5'h00, 5'h1F, 16'h0000, 16'h0, 1'b0);
        run_txn(1'b1, 5'h15, 5'h0A, 16'h0, 16'hA5C3, 1'b0);
        run_txn(1'b0, 5'h0A, 5'h15, 16'h8001, 16'h0, 1'b0);   // R10 hold across write
        run_txn(1'b1, 5'h01, 5'h10, 16'h0, 16'h0001, 1'b1);   // R9 strobe mid-read
        run_txn(1'b0, 5'h03, 5'h07, 16'h1234, 16'h0, 1'b1);   // R9 strobe mid-write

        // R12: new start in the done cycle
        start_txn(1'b1, 5'h11, 5'h05, 16'h0, 16'hBEEF);
        finish_txn(1'b0);
        chk(done == 1'b1, "R12", "done visible when chaining", 32'(done), 32'd1);
        start_txn(1'b0, 5'h06, 5'h19, 16'h5AA5, 16'h0);
        chk(rd_data == 16'hBEEF, "R12", "previous read word kept", 32'(rd_data), 32'hBEEF);
        finish_txn(1'b0);
        @(negedge clk);

        // constrained random mix
        for (int i = 0; i < 30; i++) begin
            bit rd;
            rd = 1'($urandom_range(0, 1));
            run_txn(rd, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 1'b0);
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        chk(done_long == 0, "R8", "done never wider than one cycle", 32'(done_long), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule